// File: doc/BRIEF.md
# Ready-Pattern Stream Sink

This block terminates a valid/ready packet channel into a small internal FIFO. A downstream consumer drains the FIFO through a pop interface. The pattern on the input ready line is set by a two-bit policy mode. In the wait-for-valid policy, ready answers an observed valid. In the eager policy, ready stays high whenever there is space. In the random policy, ready follows a pseudo-random coin on each cycle. Ready is always gated by FIFO space, so a consumer that stops popping pushes backpressure straight back onto the input channel.

The policy can be rewritten at runtime through a one-cycle mode write. A bench or system model can therefore sweep handshake patterns without rebuilding anything.

Inside the block, a mode register holds the active policy. A four-state ready controller turns the policy into a ready qualifier:

- **HOLD**: ready low, waiting for valid.
- **ARMED**: ready high after valid was seen.
- **OPEN**: the eager policy.
- **DICE**: the random policy.

Transitions:

- HOLD→ARMED when valid is sampled high under the wait-for-valid policy.
- ARMED→HOLD when a packet is accepted.
- Any state→OPEN under the eager policy.
- Any state→DICE under the random policy.
- OPEN or DICE→HOLD (or directly to ARMED if valid is high) on a switch back to wait-for-valid.

A 16-bit LFSR steps on every clock and supplies the random coin.

Top module: `rdy_pattern_sink`

## Requirements
- R1: A synchronous reset (`rst` high) empties the FIFO (`out_valid` low), holds `in_ready` low in the first cycle after release, and restores the default policy (eager, code 1), so `in_ready` is high from the second cycle after release.
- R2: A packet is stored only in a cycle where `in_valid` and `in_ready` are both high; packets leave in arrival order, with `out_data` showing the oldest stored packet while `out_valid` is high.
- R3: The FIFO holds `DEPTH` packets; while it is full `in_ready` is low under every policy, and it may rise again in the cycle after a pop.
- R4: Policy code 0 (wait-for-valid): `in_ready` stays low until `in_valid` has been sampled high at a clock edge, rises in the following cycle, and is low in the cycle after each accepted packet, so with `in_valid` held high it alternates.
- R5: Policy code 1 (eager): `in_ready` is high in every cycle in which the FIFO has room.
- R6: Policy code 2 (random): `in_ready` is decided afresh each cycle by a pseudo-random bit and is high only when there is room; over a long window with room it is neither stuck high nor stuck low.
- R7: Writing `mode_val` with `mode_wr` high at a clock edge installs the new policy, and the `in_ready` pattern follows it from the second cycle after that edge.
- R8: A mode write with the reserved code 3 is ignored; the previous policy stays in force.
- R9: A pop request (`out_pop`) while the FIFO is empty has no effect: `out_valid` stays low and later packets come out intact and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input channel valid |
| in_data | input | DATA_W | Input channel packet |
| in_ready | output | 1 | Input channel ready, per active policy and FIFO space |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 2 | New policy: 0 wait-for-valid, 1 eager, 2 random, 3 reserved |
| out_valid | output | 1 | FIFO holds at least one packet |
| out_data | output | DATA_W | Oldest stored packet |
| out_pop | input | 1 | Consumer removes the oldest packet |

## Verification
A wrong mode register or controller state shows at the ports within two cycles. It appears as a ready that rises before any valid, fails to drop after an accept, or ignores a policy write. A miscounted FIFO shows as ready staying high at the `DEPTH`-th stored packet, or as `out_valid` disagreeing with the number of packets handed in and popped. A corrupted pointer shows on the next pop as a packet out of order. The bench keeps a reference queue and a one-bit armed model, and compares ready, `out_valid` and `out_data` against them in every cycle under random traffic. Directed cases cover reset, filling, popping an empty FIFO and the reserved code.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        POL_WAIT_VALID = 2'd0,
        POL_EAGER      = 2'd1,
        POL_RANDOM     = 2'd2,
        POL_RSVD       = 2'd3
    } pol_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2,
        ST_DICE  = 2'd3
    } rdy_state_e;

endpackage

// File: rtl/rps_lfsr.sv
module rps_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    output logic coin
);

    logic [W-1:0] q;
    logic [W-1:0] q_nxt;

    always_comb begin
        q_nxt = {1'b0, q[W-1:1]};
        if (q[0]) q_nxt = q_nxt ^ TAPS[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= SEED[W-1:0];
        else     q <= q_nxt;
    end

    assign coin = q[0];

    // R6: the generator never locks up in the all-zero state
    p_lfsr_alive_r6: assert property (@(posedge clk) disable iff (rst)
        q != '0);

endmodule

// File: rtl/rps_fifo.sv
module rps_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd, empty;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_MAX);
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_en && !empty;
    assign rd_valid = !empty;
    assign rd_data  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3: occupancy never exceeds the capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_MAX);

    // R9: a lone pop on an empty FIFO leaves it empty
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> empty);

    // R2: a lone accepted write raises occupancy by exactly one
    p_write_counts_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !rd_en) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rps_mode_reg.sv
module rps_mode_reg
    import rps_pkg::*;
#(
    parameter pol_mode_e DEFAULT_MODE = POL_EAGER
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [1:0] val,
    output pol_mode_e mode
);

    logic legal;
    assign legal = (pol_mode_e'(val) != POL_RSVD);

    always_ff @(posedge clk) begin
        if (rst)              mode <= DEFAULT_MODE;
        else if (wr && legal) mode <= pol_mode_e'(val);
    end

    // R8: the reserved code is never installed
    p_no_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        mode != POL_RSVD);

    // R8: a reserved write leaves the policy unchanged
    p_rsvd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && val == 2'd3) |=> $stable(mode));

    // R7: a legal write lands on the next edge
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && val != 2'd3) |=> (mode == pol_mode_e'($past(val))));

endmodule

// File: rtl/rps_ready_fsm.sv
module rps_ready_fsm
    import rps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pol_mode_e mode,
    input  logic      in_valid,
    input  logic      accept,
    input  logic      coin,
    output logic      pol_ready
);

    rdy_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (mode)
            POL_WAIT_VALID: begin
                if (state == ST_ARMED) state_nxt = accept ? ST_HOLD : ST_ARMED;
                else                   state_nxt = in_valid ? ST_ARMED : ST_HOLD;
            end
            POL_EAGER:  state_nxt = ST_OPEN;
            POL_RANDOM: state_nxt = ST_DICE;
            POL_RSVD:   state_nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_HOLD:  pol_ready = 1'b0;
            ST_ARMED: pol_ready = 1'b1;
            ST_OPEN:  pol_ready = 1'b1;
            ST_DICE:  pol_ready = coin;
        endcase
    end

    // R4: arming needs valid to have been seen at the previous edge
    p_arm_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) == ST_HOLD) |-> $past(in_valid));

    // R4: an accepted packet disarms the controller
    p_drop_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && accept) |=> (state != ST_ARMED));

    // R5: a settled eager policy keeps the controller open
    p_eager_open_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_EAGER && $past(mode) == POL_EAGER && !$past(rst)) |-> (state == ST_OPEN));

endmodule

// File: rtl/rdy_pattern_sink.sv
module rdy_pattern_sink
    import rps_pkg::*;
#(
    parameter int          DATA_W       = 32,
    parameter int          DEPTH        = 8,
    parameter logic [15:0] LFSR_SEED    = 16'hACE1,
    parameter pol_mode_e   DEFAULT_MODE = POL_EAGER
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              mode_wr,
    input  logic [1:0]        mode_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_pop
);

    pol_mode_e mode;
    logic      coin, pol_ready, full, accept;

    rps_mode_reg #(.DEFAULT_MODE(DEFAULT_MODE)) u_mode (
        .clk  (clk),
        .rst  (rst),
        .wr   (mode_wr),
        .val  (mode_val),
        .mode (mode)
    );

    rps_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .coin (coin)
    );

    rps_ready_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .in_valid  (in_valid),
        .accept    (accept),
        .coin      (coin),
        .pol_ready (pol_ready)
    );

    assign in_ready = pol_ready && !full;
    assign accept   = in_valid && in_ready;

    rps_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_data  (in_data),
        .rd_en    (out_pop),
        .rd_data  (out_data),
        .rd_valid (out_valid),
        .full     (full)
    );

    // R1: the cycle after reset has neither ready nor stored data
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ready && !out_valid));

endmodule

// File: tb/sim_rdy_pattern_sink.sv
module sim_rdy_pattern_sink;

    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_val = 2'd0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_pop = 1'b0;

    always #2 clk = ~clk;

    rdy_pattern_sink #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mode_wr(mode_wr), .mode_val(mode_val),
        .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] q[$];
    int   cur_mode = 1;
    bit   armed = 0;
    bit   mode_chk = 0;
    logic last_ready;
    int   rnd_room, rnd_high;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ready_m0(input bit arm, input int size);
        return arm && (size < DEPTH);
    endfunction

    task automatic cyc(input logic v, input logic [DW-1:0] d, input logic p);
        bit acc, pp;
        in_valid = v; in_data = d; out_pop = p;
        #1;
        last_ready = in_ready;
        chk(out_valid == (q.size() != 0), "R2 out_valid", out_valid, q.size() != 0);
        if (out_valid && q.size() != 0) chk(out_data == q[0], "R2 order", out_data, q[0]);
        if (q.size() == DEPTH) chk(!in_ready, "R3 full blocks ready", in_ready, 0);
        if (mode_chk && cur_mode == 1) chk(in_ready == (q.size() < DEPTH), "R5 eager", in_ready, q.size() < DEPTH);
        if (mode_chk && cur_mode == 0) chk(in_ready == exp_ready_m0(armed, q.size()), "R4 wait", in_ready, exp_ready_m0(armed, q.size()));
        if (mode_chk && cur_mode == 2 && q.size() < DEPTH) begin
            rnd_room++;
            if (in_ready) rnd_high++;
        end
        acc = v && in_ready;
        pp  = p && out_valid;
        @(posedge clk); #1;
        if (pp && q.size() != 0) void'(q.pop_front());
        if (acc) q.push_back(d);
        if (cur_mode == 0) armed = armed ? !acc : v;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_chk = 0;
        mode_wr = 1'b1; mode_val = m;
        cyc(0, '0, 0);
        mode_wr = 1'b0;
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        if (m != 2'd3) begin
            if (m == 2'd0 && cur_mode != 0) armed = 0;
            cur_mode = m;
        end
        mode_chk = 1;
    endtask

    task automatic do_reset();
        mode_chk = 0;
        rst = 1'b1; in_valid = 0; out_pop = 0; mode_wr = 0;
        repeat (2) @(posedge clk);
        #1; rst = 1'b0;
        q.delete(); cur_mode = 1; armed = 0;
        #1;
        chk(!in_ready, "R1 ready low after reset", in_ready, 0);
        chk(!out_valid, "R1 fifo empty after reset", out_valid, 0);
        @(posedge clk); #1;
        chk(in_ready, "R1 default eager policy", in_ready, 1);
        mode_chk = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic seq[4];
        int fill_ready;
        void'($urandom(32'd20240611));
        do_reset();

        // R3 R5: fill in eager mode with valid held
        fill_ready = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            cyc(1, 32'h100 + i, 0);
            if (last_ready) fill_ready++;
        end
        chk(fill_ready == DEPTH, "R3 accepts exactly DEPTH", fill_ready, DEPTH);
        cyc(1, 32'h200, 1);
        chk(!last_ready, "R3 ready low in pop cycle", last_ready, 0);
        cyc(1, 32'h201, 0);
        chk(last_ready, "R3 ready back after pop", last_ready, 1);
        // R2: drain and check order
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, '0, 1);
        chk(q.size() == 0 && !out_valid, "R2 drained", out_valid, 0);

        // R9: pop while empty
        for (int i = 0; i < 4; i++) cyc(0, '0, 1);
        chk(!out_valid, "R9 pop on empty", out_valid, 0);
        cyc(1, 32'hCAFE0001, 1);
        cyc(1, 32'hCAFE0002, 0);
        chk(out_data == 32'hCAFE0001, "R9 data after empty pops", out_data, 32'hCAFE0001);
        for (int i = 0; i < 3; i++) cyc(0, '0, 1);

        // R4 R7: wait-for-valid directed
        set_mode(2'd0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, '0, 0);
            chk(!last_ready, "R4 no ready before valid", last_ready, 0);
        end
        for (int i = 0; i < 4; i++) begin
            cyc(1, 32'h300 + i, 0);
            seq[i] = last_ready;
        end
        chk(seq[0] == 0 && seq[1] == 1 && seq[2] == 0 && seq[3] == 1,
            "R4 alternating ready", {seq[0], seq[1], seq[2], seq[3]}, 4'b0101);
        for (int i = 0; i < 4; i++) cyc(0, '0, 1);

        // R8: reserved code keeps wait-for-valid
        set_mode(2'd3);
        cyc(1, 32'h400, 0);
        chk(!last_ready, "R8 reserved write ignored", last_ready, 0);
        cyc(1, 32'h401, 0);
        chk(last_ready, "R8 still wait-for-valid", last_ready, 1);
        for (int i = 0; i < 3; i++) cyc(0, '0, 1);

        // R4: random traffic under wait-for-valid
        for (int i = 0; i < 1500; i++) cyc($urandom_range(0, 1), $urandom, ($urandom_range(0, 3) != 0));

        // R5 R7: random traffic under eager
        set_mode(2'd1);
        for (int i = 0; i < 1500; i++) cyc(($urandom_range(0, 3) != 0), $urandom, $urandom_range(0, 1));

        // R6: random policy statistics
        set_mode(2'd2);
        for (int i = 0; i < 6; i++) cyc(0, '0, 1);
        rnd_room = 0; rnd_high = 0;
        for (int i = 0; i < 400; i++) cyc(1, $urandom, 1);
        chk(rnd_high > rnd_room / 5 && rnd_high < (rnd_room * 4) / 5,
            "R6 random ready mix", rnd_high, rnd_room / 2);
        for (int i = 0; i < 200; i++) cyc(1, $urandom, 0);
        chk(q.size() == DEPTH, "R6 random fills to capacity", q.size(), DEPTH);
        for (int i = 0; i < 20; i++) cyc(1, $urandom, 0);

        // R1: reset mid-run restores default policy
        set_mode(2'd0);
        cyc(1, 32'h500, 1);
        do_reset();
        cyc(0, '0, 0);
        chk(last_ready, "R1 eager after reset without valid", last_ready, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule